// File: doc/BRIEF.md
# Parallel Display Write-Bus Master

This block turns single write requests into cycles on a write-only, 8080-style parallel bus that feeds a display bridge. Each request carries a 16-bit word and a flag that says whether the word is a command or data. The flag drives the data/command select line the way an address bit would be driven. A register write on the bridge is two requests in a row: a command word that holds the register index, then a data word that holds the value.

Each bus cycle has an address-setup phase and then a strobe phase, and the write strobe is low during the strobe phase. Both lengths are read from run-time inputs and counted in system-clock cycles. Firmware can therefore run the bus slowly while the bridge runs from its raw oscillator (for example 5 setup and 5 strobe cycles at 16 MHz, which is more than 300 ns). It can then shorten the strobe phase once the bridge PLL has locked (for example 5 setup and 2 strobe cycles). The bus has no address hold. Chip select frames every single word, and the read strobe stays inactive.

Top module: `lcd_pbus_master`

## Requirements
- R1: `bus_dc` is 0 during a cycle whose request had `req_is_data`=0 (command) and 1 during a cycle whose request had `req_is_data`=1 (data).
- R2: On the first clock edge after acceptance, `bus_cs_n` goes low while `bus_wr_n` stays high. This setup phase lasts `cfg_setup` clock cycles, and `bus_d` holds the accepted word for the whole phase.
- R3: After the setup phase, `bus_wr_n` is low for `cfg_strobe` clock cycles while `bus_cs_n` stays low and `bus_d` still holds the word.
- R4: A setup count of 0 or a strobe count of 0 gives a phase of one clock cycle.
- R5: In the clock cycle right after the strobe phase, `bus_cs_n` is high. Every word gets its own chip-select assertion.
- R6: `req_ready` is 1 only when the bus is idle. It is 0 from the edge that accepts a request until the idle cycle after the strobe has passed. A request presented while `req_ready` is 0 has no effect on the bus cycle in progress.
- R7: `cfg_setup` and `cfg_strobe` are sampled at acceptance. A change to either one while a cycle is in progress does not alter that cycle's phase lengths.
- R8: `bus_rd_n` is 1 at all times.
- R9: `bus_oe` is 1 exactly when `bus_cs_n` is 0. While `bus_oe` is 0, `bus_d` is 0.
- R10: `busy` is 1 from acceptance until the idle cycle after the strobe has passed, and 0 otherwise.
- R11: While reset is held and after it is released, `bus_cs_n`=1, `bus_wr_n`=1, `bus_rd_n`=1, `bus_oe`=0, `req_ready`=1 and `busy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all phase lengths count its cycles |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | A write request is presented |
| req_ready | output | 1 | The master can accept a request |
| req_word | input | 16 | Word to place on the bus |
| req_is_data | input | 1 | 1 = data word, 0 = command word |
| cfg_setup | input | 4 | Setup phase length in cycles (0 treated as 1) |
| cfg_strobe | input | 4 | Strobe phase length in cycles (0 treated as 1) |
| busy | output | 1 | A bus cycle or its trailing idle cycle is in progress |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_dc | output | 1 | Data/command select: 0 command, 1 data |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_rd_n | output | 1 | Read strobe, always inactive (high) |
| bus_d | output | 16 | Bus data |
| bus_oe | output | 1 | Bus data output enable |

## Verification
Cycles are issued under the slow pre-PLL timing and the fast post-PLL timing, and as command and data words, which separates the two levels of the select line and the two phase lengths. Zero counts and the largest count show whether clamping and counter width are right. One register-write pair (index word, then value) shows that chip select is released between the two words. A disturbed run retimes the inputs and presents a conflicting request in the middle of a cycle. That run tells a design that samples the timing at acceptance apart from one that follows the live inputs or takes requests while busy.

// File: rtl/pbus_pkg.sv
package pbus_pkg;
   typedef enum logic [1:0] {
      PH_IDLE   = 2'd0,
      PH_SETUP  = 2'd1,
      PH_STROBE = 2'd2,
      PH_GAP    = 2'd3
   } pbus_phase_e;
endpackage

// File: rtl/pbus_phase_timer.sv
module pbus_phase_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= ONE;
      else if (load)         cnt_q <= load_val;
      else if (cnt_q > ONE)  cnt_q <= cnt_q - ONE;
   end

   assign done = (cnt_q <= ONE);
endmodule

// File: rtl/pbus_seq.sv
module pbus_seq
   import pbus_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int CNT_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [DATA_W-1:0] req_word,
   input  logic              req_is_data,
   input  logic [CNT_W-1:0]  cfg_setup,
   input  logic [CNT_W-1:0]  cfg_strobe,
   input  logic              t_done,
   output logic              t_load,
   output logic [CNT_W-1:0]  t_val,
   output pbus_phase_e       phase,
   output logic [DATA_W-1:0] word_q,
   output logic              dc_q
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   pbus_phase_e      nxt;
   logic [CNT_W-1:0] setup_eff, strobe_eff, strobe_q;
   logic             accept;

   assign setup_eff  = (cfg_setup  == '0) ? ONE : cfg_setup;
   assign strobe_eff = (cfg_strobe == '0) ? ONE : cfg_strobe;
   assign accept     = req_valid && (phase == PH_IDLE);

   always_comb begin
      nxt    = phase;
      t_load = 1'b0;
      t_val  = setup_eff;
      unique case (phase)
         PH_IDLE: if (accept) begin
            t_load = 1'b1;
            t_val  = setup_eff;
            nxt    = PH_SETUP;
         end
         PH_SETUP: if (t_done) begin
            t_load = 1'b1;
            t_val  = strobe_q;
            nxt    = PH_STROBE;
         end
         PH_STROBE: if (t_done) nxt = PH_GAP;
         PH_GAP:    nxt = PH_IDLE;
         default:   nxt = PH_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         word_q   <= '0;
         dc_q     <= 1'b0;
         strobe_q <= ONE;
      end else begin
         phase <= nxt;
         if (accept) begin
            word_q   <= req_word;
            dc_q     <= req_is_data;
            strobe_q <= strobe_eff;
         end
      end
   end
endmodule

// File: rtl/pbus_pin_drive.sv
module pbus_pin_drive
   import pbus_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter bit IDLE_BUS_ZERO = 1'b1
) (
   input  pbus_phase_e       phase,
   input  logic [DATA_W-1:0] word_q,
   input  logic              dc_q,
   output logic              cs_n,
   output logic              dc,
   output logic              wr_n,
   output logic              rd_n,
   output logic [DATA_W-1:0] d,
   output logic              oe,
   output logic              ready,
   output logic              busy
);
   logic active;

   assign active = (phase == PH_SETUP) || (phase == PH_STROBE);
   assign cs_n   = !active;
   assign wr_n   = (phase != PH_STROBE);
   assign rd_n   = 1'b1;
   assign oe     = active;
   assign dc     = active ? dc_q : 1'b1;
   assign ready  = (phase == PH_IDLE);
   assign busy   = (phase != PH_IDLE);

   generate
      if (IDLE_BUS_ZERO) begin : g_idle_zero
         assign d = active ? word_q : '0;
      end else begin : g_idle_hold
         assign d = word_q;
      end
   endgenerate
endmodule

// File: rtl/lcd_pbus_master.sv
module lcd_pbus_master
   import pbus_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int CNT_W         = 4,
   parameter bit IDLE_BUS_ZERO = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [DATA_W-1:0] req_word,
   input  logic              req_is_data,
   input  logic [CNT_W-1:0]  cfg_setup,
   input  logic [CNT_W-1:0]  cfg_strobe,
   output logic              busy,
   output logic              bus_cs_n,
   output logic              bus_dc,
   output logic              bus_wr_n,
   output logic              bus_rd_n,
   output logic [DATA_W-1:0] bus_d,
   output logic              bus_oe
);
   initial begin
      if (DATA_W < 8 || DATA_W > 32) $error("lcd_pbus_master: DATA_W out of range");
      if (CNT_W < 1 || CNT_W > 16)   $error("lcd_pbus_master: CNT_W out of range");
   end

   pbus_phase_e       phase;
   logic [DATA_W-1:0] word_q;
   logic              dc_q, t_load, t_done;
   logic [CNT_W-1:0]  t_val;

   pbus_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_word(req_word),
      .req_is_data(req_is_data), .cfg_setup(cfg_setup), .cfg_strobe(cfg_strobe),
      .t_done(t_done), .t_load(t_load), .t_val(t_val), .phase(phase),
      .word_q(word_q), .dc_q(dc_q)
   );

   pbus_phase_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load(t_load), .load_val(t_val), .done(t_done)
   );

   pbus_pin_drive #(.DATA_W(DATA_W), .IDLE_BUS_ZERO(IDLE_BUS_ZERO)) u_pins (
      .phase(phase), .word_q(word_q), .dc_q(dc_q), .cs_n(bus_cs_n), .dc(bus_dc),
      .wr_n(bus_wr_n), .rd_n(bus_rd_n), .d(bus_d), .oe(bus_oe),
      .ready(req_ready), .busy(busy)
   );
endmodule

// File: rtl/lcd_pbus_master_chk.sv
module lcd_pbus_master_chk #(
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              req_ready,
   input logic              req_is_data,
   input logic              busy,
   input logic              bus_cs_n,
   input logic              bus_dc,
   input logic              bus_wr_n,
   input logic              bus_rd_n,
   input logic [DATA_W-1:0] bus_d,
   input logic              bus_oe
);
   a_r2_accept_opens_setup: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (!bus_cs_n && bus_wr_n));

   a_r1_dc_follows_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_ready) |=> (bus_dc == $past(req_is_data)));

   a_r3_strobe_inside_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr_n |-> !bus_cs_n);

   a_r5_cs_release_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!bus_wr_n) && bus_wr_n) |-> bus_cs_n);

   a_r2_word_stable_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_cs_n && $past(!bus_cs_n)) |-> ($stable(bus_d) && $stable(bus_dc)));

   a_r8_read_idle: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_n);

   a_r9_oe_with_cs: assert property (@(posedge clk) disable iff (!rst_n)
      bus_oe != bus_cs_n);

   a_r6_not_ready_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !req_ready);

   a_r10_busy_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_cs_n |-> busy);
endmodule

bind lcd_pbus_master lcd_pbus_master_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
   .req_is_data(req_is_data), .busy(busy), .bus_cs_n(bus_cs_n), .bus_dc(bus_dc),
   .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_d(bus_d), .bus_oe(bus_oe)
);

// File: tb/lcd_pbus_master_tb_top.sv
`timescale 1ns/1ps
module lcd_pbus_master_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [15:0] req_word = '0;
   logic        req_is_data = 1'b0;
   logic [3:0]  cfg_setup = 4'd5;
   logic [3:0]  cfg_strobe = 4'd5;
   logic        busy, bus_cs_n, bus_dc, bus_wr_n, bus_rd_n, bus_oe;
   logic [15:0] bus_d;

   int n_vec = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   lcd_pbus_master dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_word(req_word), .req_is_data(req_is_data), .cfg_setup(cfg_setup),
      .cfg_strobe(cfg_strobe), .busy(busy), .bus_cs_n(bus_cs_n), .bus_dc(bus_dc),
      .bus_wr_n(bus_wr_n), .bus_rd_n(bus_rd_n), .bus_d(bus_d), .bus_oe(bus_oe)
   );

   // fields: [24:9] word, [8] is_data, [7:4] setup, [3:0] strobe
   localparam logic [24:0] VEC [8] = '{
      {16'h00BA, 1'b0, 4'd5,  4'd5},
      {16'h000F, 1'b1, 4'd5,  4'd5},
      {16'h00B9, 1'b0, 4'd5,  4'd2},
      {16'h0001, 1'b1, 4'd5,  4'd2},
      {16'hF800, 1'b1, 4'd0,  4'd0},
      {16'h07E0, 1'b1, 4'd1,  4'd0},
      {16'h001F, 1'b0, 4'd0,  4'd3},
      {16'hFFFF, 1'b1, 4'd15, 4'd15}
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic idle_pins(input string tag);
      chk({tag, " cs_n"},  32'(bus_cs_n),  32'd1);
      chk({tag, " wr_n"},  32'(bus_wr_n),  32'd1);
      chk({tag, " rd_n"},  32'(bus_rd_n),  32'd1);
      chk({tag, " oe"},    32'(bus_oe),    32'd0);
      chk({tag, " ready"}, 32'(req_ready), 32'd1);
      chk({tag, " busy"},  32'(busy),      32'd0);
   endtask

   task automatic xfer(input logic [15:0] w, input logic dc, input logic [3:0] s,
                       input logic [3:0] d, input bit disturb);
      int se = (s == 0) ? 1 : int'(s);
      int de = (d == 0) ? 1 : int'(d);
      int total = se + de + 1;
      string ts = (s == 0) ? "R4 setup" : "R2 setup";
      string td = (d == 0) ? "R4 strobe" : "R3 strobe";
      @(negedge clk);
      req_word = w; req_is_data = dc; cfg_setup = s; cfg_strobe = d; req_valid = 1'b1;
      chk("R6 ready before accept", 32'(req_ready), 32'd1);
      @(posedge clk);
      @(negedge clk);
      req_valid = disturb;
      if (disturb) begin
         req_word = ~w; req_is_data = ~dc; cfg_setup = 4'd9; cfg_strobe = 4'd7;
      end
      for (int i = 1; i <= total; i++) begin
         if (i > 1) @(negedge clk);
         if (i == total) req_valid = 1'b0;
         if (i <= se) begin
            chk({disturb ? "R7 " : "", ts, " cs_n"}, 32'(bus_cs_n), 32'd0);
            chk({disturb ? "R7 " : "", ts, " wr_n"}, 32'(bus_wr_n), 32'd1);
         end else if (i <= se + de) begin
            chk({disturb ? "R7 " : "", td, " cs_n"}, 32'(bus_cs_n), 32'd0);
            chk({disturb ? "R7 " : "", td, " wr_n"}, 32'(bus_wr_n), 32'd0);
         end else begin
            chk("R5 gap cs_n", 32'(bus_cs_n), 32'd1);
            chk("R5 gap wr_n", 32'(bus_wr_n), 32'd1);
            chk("R9 gap bus_d zero", 32'(bus_d), 32'd0);
         end
         if (i < total) begin
            chk("R1 dc level", 32'(bus_dc), 32'(dc));
            chk(disturb ? "R6 word kept while busy" : "R2 word on bus", 32'(bus_d), 32'(w));
         end
         chk("R9 oe vs cs", 32'(bus_oe), 32'(!bus_cs_n));
         chk("R6 ready low", 32'(req_ready), 32'd0);
         chk("R10 busy high", 32'(busy), 32'd1);
         chk("R8 rd_n high", 32'(bus_rd_n), 32'd1);
      end
      @(negedge clk);
      idle_pins("R10 after cycle");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      idle_pins("R11 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      idle_pins("R11 after reset");

      foreach (VEC[k]) begin
         xfer(VEC[k][24:9], VEC[k][8], VEC[k][7:4], VEC[k][3:0], 1'b0);
      end

      // R7 / R6: retime inputs and offer a conflicting request mid-cycle
      xfer(16'hA55A, 1'b1, 4'd2, 4'd3, 1'b1);
      xfer(16'h002C, 1'b0, 4'd3, 4'd1, 1'b1);

      // R2: back-to-back register write; idle cycle separates the two words
      xfer(16'h00B7, 1'b0, 4'd5, 4'd2, 1'b0);
      xfer(16'h0243, 1'b1, 4'd5, 4'd2, 1'b0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule